// File: doc/BRIEF.md
# Burst Motion Register Read Port

This block is the serial slave side of a motion sensor's register file. A host drives chip select, a serial clock and serial data in, and receives serial data out. Ordinary transactions read or write one register per command, and several commands may follow one another while chip select stays low. The register contents come in on a flat parallel bus from the surrounding logic. Writes leave the block as a one-cycle strobe with address and data, and the owner of the registers applies them.

Reading one dedicated burst address switches the port into a streaming mode. When the last address bit arrives, the port takes a copy of eight motion-related registers. It then shifts that copy out as one continuous 64-bit stream, with no address phase and no gap between bytes. The host may stop early by raising chip select. A flag records a stream that ended before the X delta byte was complete. After a burst, chip select must stay high for a minimum number of system clock cycles before the next command is honoured.

All port pins are brought into the system clock domain through synchronisers. The serial clock therefore has to run several times slower than the system clock.

Top module: `mburst_port`

## Requirements
- R1: After reset, and whenever no read data is being shifted, `sdo_o` is 0, `wr_valid_o` is 0 and `burst_short_o` is 0 until a burst ends early.
- R2: `sdi_i` is sampled on rising edges of `sclk_i`, MSB first. In the first byte of a command, bit 7 set means a write and bit 7 clear means a read, and bits 6..0 carry the address. The first read data bit appears on `sdo_o` after the last address rising edge, and each later bit appears after the following rising edge.
- R3: A read of address a, with a below NREGS and not equal to BURST_ADDR, returns `reg_bank_i[8*a+7 : 8*a]`. A read of any other non-burst address returns 0.
- R4: A write command followed by 8 data bits produces exactly one `wr_valid_o` pulse of one cycle, carrying the address and the data byte.
- R5: While chip select stays low, a completed command is followed by a new command byte, so reads and writes can be chained.
- R6: A read of BURST_ADDR streams 8 bytes taken from registers BURST_BASE to BURST_BASE+7, in this order: motion status, X delta low, Y delta low, shared XY delta high bits, surface quality, shutter high, shutter low, maximum pixel.
- R7: The burst bytes are a snapshot taken when the last address bit arrives. Register changes made during the stream do not appear in it.
- R8: Once all 64 burst bits have been clocked, further clocks shift out 0 until chip select rises.
- R9: Raising chip select at any point returns the port to idle and clears the bit counter. A partial command has no effect.
- R10: `burst_short_o` is set when a burst ends after fewer than 16 data bits have been clocked, that is, before the X delta byte is complete. It is cleared when the next accepted command starts.
- R11: After a burst, chip select must stay high for BEXIT_CYCLES consecutive system clocks. A transaction that starts sooner is discarded entirely: no write happens and `sdo_o` stays 0. The wait then starts over.
- R12: The burst stream needs no pause between bytes. The host clocks all bits at the same rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| reg_bank_i | input | NREGS*8 | Register contents, register i at bits 8*i+7:8*i |
| wr_valid_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 7 | Write address |
| wr_data_o | output | 8 | Write data |
| burst_short_o | output | 1 | Last burst ended before X delta byte completed |

## Verification
The hardest situation to reach from the ports is a burst whose source registers change while the stream is running. Only the snapshot distinguishes a correct design from one that re-reads live values. The stimulus therefore inverts every burst source register after the first streamed byte and expects the old values in all later bytes. A second hard case is a command that starts inside the exit window after a burst. The bench reopens chip select after only a few high cycles, issues a write and a read, and expects no strobe and zero data. It then waits out the window and confirms that normal service returns.

// File: rtl/mburst_pkg.sv
package mburst_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = BYTE_W - 1;
  localparam int BURST_LEN = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_BURST,
    ST_DISCARD
  } sp_state_e;
endpackage

// File: rtl/mburst_sync.sv
module mburst_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= {stage_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mburst_outsr.sv
module mburst_outsr #(
  parameter int NBYTES = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic                  load_i,
  input  logic [NBYTES*8-1:0]   load_data_i,
  input  logic                  shift_i,
  output logic                  msb_o
);
  localparam int W = NBYTES * 8;

  logic [W-1:0] sr_q, sr_d;
  logic         sr_en;

  always_comb begin
    sr_en = load_i | shift_i;
    sr_d  = load_i ? load_data_i : {sr_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

  assign msb_o = sr_q[W-1];

  // R7
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!load_i && !shift_i) |=> $stable(sr_q));
endmodule

// File: rtl/mburst_exit_guard.sv
module mburst_exit_guard #(
  parameter int BEXIT_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic arm_i,
  input  logic cs_high_i,
  output logic armed_o
);
  localparam int CNT_W = $clog2(BEXIT_CYCLES + 1);

  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (arm_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q) begin
      if (!cs_high_i) begin
        cnt_d = '0;
      end else if (cnt_q == CNT_W'(BEXIT_CYCLES - 1)) begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  assign armed_o = armed_q;

  // R11
  guard_release_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(armed_q) |-> $past(cs_high_i));
endmodule

// File: rtl/mburst_ctrl.sv
module mburst_ctrl import mburst_pkg::*; #(
  parameter int                NREGS      = 16,
  parameter logic [ADDR_W-1:0] BURST_ADDR = 7'h50,
  parameter int                BURST_BASE = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_n_i,
  input  logic                      cs_low_i,
  input  logic                      cs_fall_i,
  input  logic                      cs_rise_i,
  input  logic                      sclk_rise_i,
  input  logic                      sdi_i,
  input  logic [NREGS*BYTE_W-1:0]   reg_bank_i,
  input  logic                      guard_armed_i,
  output logic                      guard_arm_o,
  output logic                      sdo_o,
  output logic                      wr_valid_o,
  output logic [ADDR_W-1:0]         wr_addr_o,
  output logic [BYTE_W-1:0]         wr_data_o,
  output logic                      burst_short_o
);
  localparam int SR_W       = BURST_LEN * BYTE_W;
  localparam int BBITS_W    = $clog2(SR_W + 1);
  localparam int SHORT_BITS = 2 * BYTE_W;

  sp_state_e           state_q, state_d;
  logic [2:0]          bitcnt_q, bitcnt_d;
  logic [ADDR_W-1:0]   in_sr_q, in_sr_d;
  logic [ADDR_W-1:0]   waddr_q, waddr_d;
  logic [BBITS_W-1:0]  bbits_q, bbits_d;
  logic                short_q, short_d;
  logic                wr_valid_q, wr_valid_d;
  logic [ADDR_W-1:0]   wr_addr_q, wr_addr_d;
  logic [BYTE_W-1:0]   wr_data_q, wr_data_d;

  logic [BYTE_W-1:0]   in_byte;
  logic [ADDR_W-1:0]   in_addr;
  logic [BYTE_W-1:0]   rd_byte;
  logic [SR_W-1:0]     burst_word;
  logic [SR_W-1:0]     ld_data;
  logic                ld, shift, sr_msb;

  generate
    for (genvar k = 0; k < BURST_LEN; k++) begin : g_burst_src
      assign burst_word[(BURST_LEN-1-k)*BYTE_W +: BYTE_W] =
        reg_bank_i[(BURST_BASE+k)*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign in_byte = {in_sr_q, sdi_i};
  assign in_addr = in_byte[ADDR_W-1:0];

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (in_addr == ADDR_W'(i)) rd_byte = reg_bank_i[i*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    state_d     = state_q;
    bitcnt_d    = bitcnt_q;
    in_sr_d     = in_sr_q;
    waddr_d     = waddr_q;
    bbits_d     = bbits_q;
    short_d     = short_q;
    wr_valid_d  = 1'b0;
    wr_addr_d   = wr_addr_q;
    wr_data_d   = wr_data_q;
    ld          = 1'b0;
    ld_data     = '0;
    shift       = 1'b0;
    guard_arm_o = 1'b0;
    if (cs_rise_i) begin
      state_d  = ST_IDLE;
      bitcnt_d = '0;
      if (state_q == ST_BURST) begin
        guard_arm_o = 1'b1;
        short_d     = (bbits_q < BBITS_W'(SHORT_BITS));
      end
    end else if (cs_fall_i) begin
      bitcnt_d = '0;
      if (guard_armed_i) begin
        state_d = ST_DISCARD;
      end else begin
        state_d = ST_ADDR;
        short_d = 1'b0;
      end
    end else if (sclk_rise_i && cs_low_i) begin
      unique case (state_q)
        ST_ADDR: begin
          in_sr_d  = in_byte[ADDR_W-1:0];
          bitcnt_d = bitcnt_q + 3'd1;
          if (bitcnt_q == 3'd7) begin
            if (in_byte[BYTE_W-1]) begin
              waddr_d = in_addr;
              state_d = ST_WDATA;
            end else if (in_addr == BURST_ADDR) begin
              state_d = ST_BURST;
              ld      = 1'b1;
              ld_data = burst_word;
              bbits_d = '0;
            end else begin
              state_d = ST_RDATA;
              ld      = 1'b1;
              ld_data = {rd_byte, {(SR_W-BYTE_W){1'b0}}};
            end
          end
        end
        ST_WDATA: begin
          in_sr_d  = in_byte[ADDR_W-1:0];
          bitcnt_d = bitcnt_q + 3'd1;
          if (bitcnt_q == 3'd7) begin
            wr_valid_d = 1'b1;
            wr_addr_d  = waddr_q;
            wr_data_d  = in_byte;
            state_d    = ST_ADDR;
          end
        end
        ST_RDATA: begin
          shift    = 1'b1;
          bitcnt_d = bitcnt_q + 3'd1;
          if (bitcnt_q == 3'd7) state_d = ST_ADDR;
        end
        ST_BURST: begin
          shift = 1'b1;
          if (bbits_q != BBITS_W'(SR_W)) bbits_d = bbits_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      in_sr_q    <= '0;
      waddr_q    <= '0;
      bbits_q    <= '0;
      short_q    <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
    end else begin
      state_q    <= state_d;
      bitcnt_q   <= bitcnt_d;
      in_sr_q    <= in_sr_d;
      waddr_q    <= waddr_d;
      bbits_q    <= bbits_d;
      short_q    <= short_d;
      wr_valid_q <= wr_valid_d;
      wr_addr_q  <= wr_addr_d;
      wr_data_q  <= wr_data_d;
    end
  end

  mburst_outsr #(.NBYTES(BURST_LEN)) outsr_i (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .load_i      (ld),
    .load_data_i (ld_data),
    .shift_i     (shift),
    .msb_o       (sr_msb)
  );

  assign sdo_o         = sr_msb & ((state_q == ST_RDATA) || (state_q == ST_BURST));
  assign wr_valid_o    = wr_valid_q;
  assign wr_addr_o     = wr_addr_q;
  assign wr_data_o     = wr_data_q;
  assign burst_short_o = short_q;

  // R9
  cs_rise_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cs_rise_i |=> (state_q == ST_IDLE && bitcnt_q == 3'd0));

  // R4
  wr_pulse_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(wr_valid_q) |-> $past(state_q) == ST_WDATA);

  // R11
  guard_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (cs_fall_i && guard_armed_i) |=> state_q == ST_DISCARD);

  // R10
  short_src_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(short_q) |-> $past(state_q) == ST_BURST);

  // R8
  burst_tail_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (state_q == ST_BURST && bbits_q == BBITS_W'(SR_W)) |-> !sdo_o);
endmodule

// File: rtl/mburst_port.sv
module mburst_port import mburst_pkg::*; #(
  parameter int                NREGS        = 16,
  parameter logic [ADDR_W-1:0] BURST_ADDR   = 7'h50,
  parameter int                BURST_BASE   = 2,
  parameter int                BEXIT_CYCLES = 32,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_n_i,
  input  logic                    cs_n_i,
  input  logic                    sclk_i,
  input  logic                    sdi_i,
  output logic                    sdo_o,
  input  logic [NREGS*BYTE_W-1:0] reg_bank_i,
  output logic                    wr_valid_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [BYTE_W-1:0]       wr_data_o,
  output logic                    burst_short_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  logic [2:0] pins_s;
  logic       cs_n_s, sclk_s, sdi_s;
  logic       cs_n_prev_q, sclk_prev_q;
  logic       cs_fall, cs_rise, sclk_rise;
  logic       guard_arm, guard_armed;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_pipe_q <= 2'b00;
    else          rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  mburst_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) sync_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n),
    .d_i     ({cs_n_i, sclk_i, sdi_i}),
    .q_o     (pins_s)
  );
  assign {cs_n_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_prev_q <= 1'b1;
      sclk_prev_q <= 1'b1;
    end else begin
      cs_n_prev_q <= cs_n_s;
      sclk_prev_q <= sclk_s;
    end
  end

  assign cs_fall   = cs_n_prev_q & ~cs_n_s;
  assign cs_rise   = ~cs_n_prev_q & cs_n_s;
  assign sclk_rise = ~sclk_prev_q & sclk_s;

  mburst_exit_guard #(.BEXIT_CYCLES(BEXIT_CYCLES)) guard_i (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n),
    .arm_i     (guard_arm),
    .cs_high_i (cs_n_s),
    .armed_o   (guard_armed)
  );

  mburst_ctrl #(.NREGS(NREGS), .BURST_ADDR(BURST_ADDR), .BURST_BASE(BURST_BASE)) ctrl_i (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n),
    .cs_low_i      (~cs_n_s),
    .cs_fall_i     (cs_fall),
    .cs_rise_i     (cs_rise),
    .sclk_rise_i   (sclk_rise),
    .sdi_i         (sdi_s),
    .reg_bank_i    (reg_bank_i),
    .guard_armed_i (guard_armed),
    .guard_arm_o   (guard_arm),
    .sdo_o         (sdo_o),
    .wr_valid_o    (wr_valid_o),
    .wr_addr_o     (wr_addr_o),
    .wr_data_o     (wr_data_o),
    .burst_short_o (burst_short_o)
  );
endmodule

// File: tb/mburst_port_tb_top.sv
module mburst_port_tb_top;
  localparam int         NREGS  = 16;
  localparam logic [6:0] BADDR  = 7'h50;
  localparam int         BBASE  = 2;
  localparam int         BEXIT  = 32;
  localparam int         HALF   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cs_n, sclk, sdi, sdo, wr_valid, short_flag;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic [7:0] bank [NREGS];
  logic [NREGS*8-1:0] bank_flat;

  always_comb begin
    for (int i = 0; i < NREGS; i++) bank_flat[i*8 +: 8] = bank[i];
  end

  mburst_port #(.NREGS(NREGS), .BURST_ADDR(BADDR), .BURST_BASE(BBASE),
                .BEXIT_CYCLES(BEXIT)) dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .reg_bank_i(bank_flat), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .burst_short_o(short_flag)
  );

  int n_tests = 0, n_fail = 0, wr_seen = 0;
  bit done = 0;
  logic [7:0]  exp_q [$];
  string       exp_tag [$];
  logic [7:0]  act_q [$];
  logic [14:0] wexp_q [$];
  string       wtag [$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (act_q.size() > 0) begin
      logic [7:0] a;
      a = act_q.pop_front();
      if (exp_q.size() == 0) chk("R2 unexpected read byte", {24'h0, a}, 32'hFFFF_FFFF);
      else chk(exp_tag.pop_front(), {24'h0, a}, {24'h0, exp_q.pop_front()});
    end
    if (wr_valid === 1'b1) begin
      wr_seen++;
      if (wexp_q.size() == 0) chk("R11 unexpected write", {17'h0, wr_addr, wr_data}, 32'hFFFF_FFFF);
      else chk(wtag.pop_front(), {17'h0, wr_addr, wr_data}, {17'h0, wexp_q.pop_front()});
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sclk = 1'b0; sdi = b;
    wait_clk(HALF);
    r = sdo;
    sclk = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      bit_x(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic cs_off(input int n);
    cs_n = 1'b1; wait_clk(n);
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] e, input string tag);
    logic [7:0] d;
    byte_x({1'b0, a}, d);
    exp_q.push_back(e); exp_tag.push_back(tag);
    byte_x(8'h00, d);
    act_q.push_back(d);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] v, input bit expect_it, input string tag);
    logic [7:0] d;
    if (expect_it) begin wexp_q.push_back({a, v}); wtag.push_back(tag); end
    byte_x({1'b1, a}, d);
    byte_x(v, d);
  endtask

  // nbytes streamed; mutate sources after the first byte when requested
  task automatic do_burst(input int nbytes, input bit mutate, input string tag);
    logic [7:0] d;
    logic [7:0] snap [8];
    for (int k = 0; k < 8; k++) snap[k] = bank[BBASE+k];
    byte_x({1'b0, BADDR}, d);
    for (int k = 0; k < nbytes; k++) begin
      exp_q.push_back(k < 8 ? snap[k] : 8'h00); exp_tag.push_back(tag);
      byte_x(8'h00, d);
      act_q.push_back(d);
      if (k == 0 && mutate) begin
        for (int j = 0; j < 8; j++) bank[BBASE+j] = ~bank[BBASE+j];
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int w0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
    for (int i = 0; i < NREGS; i++) bank[i] = 8'(8'h11 * i + 8'h03);
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    chk("R1 sdo after reset", {31'h0, sdo}, 0);
    chk("R1 wr_valid after reset", {31'h0, wr_valid}, 0);
    chk("R1 short flag after reset", {31'h0, short_flag}, 0);

    // R2 R3 single reads
    cs_on(); do_read(7'd3, bank[3], "R3 read reg3"); cs_off(10);
    cs_on(); do_read(7'd15, bank[15], "R3 read reg15"); cs_off(10);
    cs_on(); do_read(7'h20, 8'h00, "R3 read unmapped"); cs_off(10);
    bank[0] = 8'hA5;
    cs_on(); do_read(7'd0, 8'hA5, "R2 read reg0 pattern"); cs_off(10);

    // R4 write, R5 chained commands
    cs_on(); do_write(7'd5, 8'h3C, 1, "R4 write reg5"); cs_off(10);
    cs_on();
    do_read(7'd6, bank[6], "R5 chain read reg6");
    do_write(7'd12, 8'hC3, 1, "R5 chain write reg12");
    do_read(7'd1, bank[1], "R5 chain read reg1");
    cs_off(10);

    // R6 R7 R8 R12 full burst with mutation and tail
    bank[BBASE] = 8'h81;
    cs_on(); do_burst(10, 1, "R7 R8 burst snapshot stream"); cs_off(10);
    chk("R10 full burst not short", {31'h0, short_flag}, 0);

    // R11 early restart discarded
    w0 = wr_seen;
    cs_on();
    do_write(7'd4, 8'h77, 0, "R11 discarded write");
    do_read(7'd3, 8'h00, "R11 discarded read");
    cs_off(10);
    chk("R11 no write in guard window", wr_seen, w0);
    cs_off(50);
    cs_on(); do_write(7'd4, 8'h77, 1, "R11 write after window"); cs_off(10);
    cs_on(); do_read(7'd3, bank[3], "R11 read after window"); cs_off(10);

    // R6 R12 burst cut after X delta
    cs_on(); do_burst(2, 0, "R6 burst cut after two bytes"); cs_off(10);
    chk("R10 cut after X delta not short", {31'h0, short_flag}, 0);
    cs_off(50);

    // R10 burst cut before X delta complete
    cs_on(); do_burst(1, 0, "R6 burst cut after one byte"); cs_off(10);
    chk("R10 short flag set", {31'h0, short_flag}, 1);
    cs_off(50);
    cs_on(); do_read(7'd9, bank[9], "R10 read clears flag"); cs_off(10);
    chk("R10 short flag cleared", {31'h0, short_flag}, 0);

    // R9 partial commands
    w0 = wr_seen;
    cs_on();
    begin
      logic r;
      bit_x(1'b1, r); bit_x(1'b0, r); bit_x(1'b0, r);
    end
    cs_off(10);
    cs_on(); do_read(7'd4, bank[4], "R9 read after partial address"); cs_off(10);
    cs_on();
    begin
      logic [7:0] d;
      logic r;
      byte_x({1'b1, 7'd7}, d);
      for (int i = 0; i < 4; i++) bit_x(1'b1, r);
    end
    cs_off(10);
    chk("R9 partial write has no effect", wr_seen, w0);
    chk("R1 sdo idle at end", {31'h0, sdo}, 0);

    wait_clk(10);
    chk("R2 scoreboard drained", exp_q.size() + wexp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule